// File: doc/BRIEF.md
# Round-Robin Stream Event Builder

This block gathers one event from each of up to twelve per-stream FIFOs and merges them into a single output event. A 4-bit stream address selects one FIFO at a time, in ascending order. The FIFO logic outside the block answers that address with two signals. The first is an enable-status bit for the addressed stream. The second is a data-valid bit, raised together with a 9-bit word when the block requests data. Streams that are not enabled are passed over. An enabled stream is drained until the word carrying the end-of-event marker (bit 8) arrives. The block waits as long as needed for that word.

Each merged event is written toward a page writer as 16-bit words with a word offset. Body words start at offset 4. The four header words are written at offsets 0 to 3 once the last stream has been handled. A commit pulse accompanies the final header write. Words can be formatted in two ways. The raw format carries the stream word unchanged, tagged with the stream number. The decoded format uses a simple hit extractor: each hit becomes one output word plus a histogram increment request. A sampling control chooses between two behaviours. Either the start of an event waits for a free output page, or events run at full speed and only those that found a free page at their start are written out. A 32-bit event counter and an error-event counter are kept and reported in the header.

Top module: `evt_assembler`

## Requirements
- R1: A new event starts only in a cycle in which `rd_en` is high. With `rd_en` low and the block idle, `rd_req` stays low and no FIFO word is consumed.
- R2: During an event, `sadd` steps through 0, 1, …, NUM_STREAMS-1 in order. A stream with `stream_en` low is left after one cycle without any request. After the last stream, `sadd` returns to 0.
- R3: While the addressed stream is enabled, `rd_req` is high. A word is taken only in a cycle where `rd_req` and `data_valid` are both high. The block stays on that stream until it takes a word with bit 8 set.
- R4: If an enabled stream never raises `data_valid`, the block waits with `sadd` unchanged and `rd_req` high, with no timeout.
- R5: Raw mode (`raw_mode`=1 at event start) writes every taken word as bits 15:13 = 0, bits 12:9 = stream number, bit 8 = end marker, bits 7:0 = data byte. Raw mode issues no histogram requests.
- R6: Decoded mode (`raw_mode`=0 at event start) treats taken words in three ways, and the chip number starts at 0 for every stream:
  - Bit 8 = 0, bit 7 = 1: a chip word. It loads the chip number from bits 3:0 and writes nothing. If any of bits 6:4 is set, the event is marked as errored.
  - Bit 8 = 0, bit 7 = 0: a hit on strip bits 6:0. It writes {0, stream[3:0], chip[3:0], strip[6:0]}. It also pulses `hist_req` with `hist_addr` = {stream (14:11), chip (10:7), strip (6:0)}.
  - Bit 8 = 1: an end marker. It writes 0x8000 | stream<<8 and ignores the data byte.
- R7: After the last stream, four header words are written at offsets 0 to 3:
  - offset 0: {0, error flag, word count in bits 13:0}, where the word count includes the four header words;
  - offset 1: the error counter;
  - offset 2: the event counter, bits 15:0;
  - offset 3: the event counter, bits 31:16.
  `evt_done` pulses in the same cycle as the offset-3 write.
- R8: With `sample_all`=1, no event starts while `page_free` is low.
- R9: With `sample_all`=0, an event starts regardless of `page_free`. Whether it is written out is fixed by `page_free` in its start cycle. A dropped event causes no `out_we` and no `evt_done`, but still produces its histogram requests.
- R10: `evt_count` is 32 bits and increases by one per completed event, whether or not the event was written out. The header carries the count that already includes that event.
- R11: `err_count` increases by one per decoded-mode event with an error mark. Raw-mode events never change it.
- R12: After reset, `sadd`=0, `rd_req`=0, `out_we`=0, `hist_req`=0, `evt_done`=0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Readout enable; allows new events to start |
| sample_all | input | 1 | 1: wait for a free page before each event; 0: run at full speed |
| raw_mode | input | 1 | 1: raw formatting, 0: decoded formatting (latched at event start) |
| page_free | input | 1 | At least one output page can accept an event |
| sadd | output | 4 | Stream address of the FIFO being interrogated |
| stream_en | input | 1 | Addressed stream is enabled |
| data_valid | input | 1 | Addressed FIFO presents a word in answer to `rd_req` |
| rd_req | output | 1 | Word request to the addressed FIFO |
| din | input | 9 | FIFO word; bit 8 is the end-of-event marker |
| out_we | output | 1 | Page write strobe |
| out_addr | output | 14 | Word offset within the page |
| out_data | output | 16 | Word to write |
| evt_done | output | 1 | Event complete; page may be handed over |
| hist_req | output | 1 | Histogram increment request |
| hist_addr | output | 15 | Histogram bin: stream, chip, strip |
| evt_count | output | 32 | Events read from the FIFOs since reset |
| err_count | output | 16 | Decoded events with an error mark since reset |

## Verification
A table of events is used, each with its own pattern:
- all twelve streams enabled;
- sparse enables, including only the first and last stream;
- no stream enabled, which yields a header-only event of word count 4;
- a stream enabled with no words at all;
- FIFOs that answer only every other cycle.

Each event runs in raw or decoded mode, with or without a bad chip word. These cases separate correct skipping and ordering from off-by-one stream handling. They show that bubbles in `data_valid` neither lose nor duplicate words. They also show that the error mark reaches the counter only in decoded mode.

Directed runs cover further cases. One holds readout disabled with data waiting. One leaves an enabled FIFO empty to show the indefinite stall. One withholds the free page in both sampling modes. One removes the page after an event has started, which must not cancel that event's delivery.

// File: rtl/evb_pkg.sv
package evb_pkg;
   localparam int OUT_W     = 16;
   localparam int BYTE_W    = 8;
   localparam int IN_W      = BYTE_W + 1;
   localparam int CHIP_W    = 4;
   localparam int STRIP_W   = 7;
   localparam int HDR_WORDS = 4;
   localparam int HIDX_W    = $clog2(HDR_WORDS);

   typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_HDR} scan_st_e;
   typedef enum logic [1:0] {WK_CHIP, WK_HIT, WK_EOS} word_kind_e;
endpackage

// File: rtl/evb_scan.sv
module evb_scan
   import evb_pkg::*;
#(
   parameter int NUM_STREAMS = 12,
   parameter int SADD_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              sample_all,
   input  logic              page_free,
   input  logic              stream_en,
   input  logic              data_valid,
   input  logic              eos,
   output logic [SADD_W-1:0] sadd,
   output logic              rd_req,
   output logic              accept,
   output logic              evt_start,
   output logic              scan_end,
   output logic              deliver,
   output logic              hdr_active,
   output logic [HIDX_W-1:0] hdr_idx
);
   localparam logic [SADD_W-1:0] LAST     = SADD_W'(NUM_STREAMS - 1);
   localparam logic [HIDX_W-1:0] HDR_LAST = HIDX_W'(HDR_WORDS - 1);

   scan_st_e          st_q;
   logic [SADD_W-1:0] sadd_q, sadd_inc;
   logic [HIDX_W-1:0] hidx_q;
   logic              dlv_q;
   logic              go, adv, at_last;

   assign at_last = (sadd_q == LAST);
   assign go      = (st_q == SC_IDLE) && rd_en && (!sample_all || page_free);
   assign rd_req  = (st_q == SC_SCAN) && stream_en;
   assign accept  = rd_req && data_valid;
   assign adv     = (st_q == SC_SCAN) && (!stream_en || (data_valid && eos));

   generate
      if (NUM_STREAMS == (1 << SADD_W)) begin : g_natural_wrap
         assign sadd_inc = sadd_q + 1'b1;
      end else begin : g_compare_wrap
         assign sadd_inc = at_last ? '0 : sadd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SC_IDLE;
         sadd_q <= '0;
         hidx_q <= '0;
         dlv_q  <= 1'b0;
      end else begin
         case (st_q)
            SC_IDLE: if (go) begin
               st_q   <= SC_SCAN;
               sadd_q <= '0;
               dlv_q  <= page_free;
            end
            SC_SCAN: if (adv) begin
               sadd_q <= sadd_inc;
               if (at_last) begin
                  st_q   <= SC_HDR;
                  hidx_q <= '0;
               end
            end
            default: begin
               hidx_q <= hidx_q + 1'b1;
               if (hidx_q == HDR_LAST) st_q <= SC_IDLE;
            end
         endcase
      end
   end

   assign sadd       = sadd_q;
   assign evt_start  = go;
   assign scan_end   = adv && at_last;
   assign deliver    = dlv_q;
   assign hdr_active = (st_q == SC_HDR);
   assign hdr_idx    = hidx_q;

   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SC_IDLE && !rd_en) |=> (st_q == SC_IDLE));
   a_r2_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SC_SCAN && !stream_en && !at_last) |=> (sadd_q == $past(sadd_q) + 1'b1));
   a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !data_valid) |=> (sadd_q == $past(sadd_q)));
   a_r8_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SC_IDLE && sample_all && !page_free) |=> !rd_req);
   a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      sadd_q <= LAST);
endmodule

// File: rtl/evb_format.sv
module evb_format
   import evb_pkg::*;
#(
   parameter int SADD_W = 4,
   parameter int WC_W   = 14,
   parameter int EVT_W  = 32,
   parameter int ERR_W  = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               evt_start,
   input  logic                               raw_mode,
   input  logic                               deliver,
   input  logic                               accept,
   input  logic [SADD_W-1:0]                  sadd,
   input  logic [IN_W-1:0]                    din,
   input  logic                               hdr_active,
   input  logic [HIDX_W-1:0]                  hdr_idx,
   input  logic [EVT_W-1:0]                   evt_count,
   input  logic [ERR_W-1:0]                   err_count,
   output logic                               out_we,
   output logic [WC_W-1:0]                    out_addr,
   output logic [OUT_W-1:0]                   out_data,
   output logic                               evt_done,
   output logic                               hist_req,
   output logic [SADD_W+CHIP_W+STRIP_W-1:0]   hist_addr,
   output logic                               err_flag
);
   localparam logic [HIDX_W-1:0] HDR_LAST = HIDX_W'(HDR_WORDS - 1);

   logic              raw_q, err_q;
   logic [CHIP_W-1:0] chip_q;
   logic [WC_W-1:0]   wc_q;
   word_kind_e        kind;
   logic [OUT_W-1:0]  w_raw, w_hit, w_eos, w_body, hdr_word;
   logic              emit;

   always_comb begin
      if (din[IN_W-1])        kind = WK_EOS;
      else if (din[BYTE_W-1]) kind = WK_CHIP;
      else                    kind = WK_HIT;
   end

   always_comb begin
      w_raw = OUT_W'({sadd, din});
      w_hit = {1'b0, sadd, chip_q, din[STRIP_W-1:0]};
      w_eos = '0;
      w_eos[OUT_W-1] = 1'b1;
      w_eos[BYTE_W +: SADD_W] = sadd;
      if (raw_q)               w_body = w_raw;
      else if (kind == WK_HIT) w_body = w_hit;
      else                     w_body = w_eos;
   end

   always_comb begin
      hdr_word = '0;
      case (hdr_idx)
         2'd0: begin
            hdr_word[OUT_W-2]    = err_q;
            hdr_word[WC_W-1:0]   = wc_q;
         end
         2'd1:    hdr_word = OUT_W'(err_count);
         2'd2:    hdr_word = evt_count[OUT_W-1:0];
         default: hdr_word = OUT_W'(evt_count >> OUT_W);
      endcase
   end

   assign emit = raw_q || (kind != WK_CHIP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q     <= 1'b0;
         err_q     <= 1'b0;
         chip_q    <= '0;
         wc_q      <= '0;
         out_we    <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
         evt_done  <= 1'b0;
         hist_req  <= 1'b0;
         hist_addr <= '0;
      end else begin
         out_we   <= 1'b0;
         hist_req <= 1'b0;
         evt_done <= 1'b0;
         if (evt_start) begin
            raw_q  <= raw_mode;
            err_q  <= 1'b0;
            chip_q <= '0;
            wc_q   <= WC_W'(HDR_WORDS);
         end else if (hdr_active) begin
            out_we   <= deliver;
            out_addr <= WC_W'(hdr_idx);
            out_data <= hdr_word;
            evt_done <= deliver && (hdr_idx == HDR_LAST);
         end else if (accept) begin
            if (emit) begin
               out_we   <= deliver;
               out_addr <= wc_q;
               out_data <= w_body;
               wc_q     <= wc_q + 1'b1;
            end
            if (!raw_q) begin
               case (kind)
                  WK_CHIP: begin
                     chip_q <= din[CHIP_W-1:0];
                     if (|din[BYTE_W-2:CHIP_W]) err_q <= 1'b1;
                  end
                  WK_HIT: begin
                     hist_req  <= 1'b1;
                     hist_addr <= {sadd, chip_q, din[STRIP_W-1:0]};
                  end
                  default: chip_q <= '0;
               endcase
            end
         end
      end
   end

   assign err_flag = err_q;

   a_r7_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |-> (out_we && out_addr == WC_W'(HDR_WORDS - 1)));
   a_r6_hist_decoded: assert property (@(posedge clk) disable iff (!rst_n)
      hist_req |-> !raw_q);
   a_r9_no_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !deliver) |=> !out_we);
endmodule

// File: rtl/evb_count.sv
module evb_count #(
   parameter int EVT_W = 32,
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_end,
   input  logic             err_flag,
   output logic [EVT_W-1:0] evt_count,
   output logic [ERR_W-1:0] err_count
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_count <= '0;
         err_count <= '0;
      end else if (scan_end) begin
         evt_count <= evt_count + 1'b1;
         if (err_flag) err_count <= err_count + 1'b1;
      end
   end

   a_r10_evt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_count != $past(evt_count)) |-> (evt_count == $past(evt_count) + 1'b1));
   a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != $past(err_count)) |-> $past(scan_end && err_flag));
endmodule

// File: rtl/evt_assembler.sv
module evt_assembler
   import evb_pkg::*;
#(
   parameter int NUM_STREAMS = 12,
   parameter int SADD_W      = 4,
   parameter int WC_W        = 14,
   parameter int EVT_W       = 32,
   parameter int ERR_W       = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd_en,
   input  logic                             sample_all,
   input  logic                             raw_mode,
   input  logic                             page_free,
   output logic [SADD_W-1:0]                sadd,
   input  logic                             stream_en,
   input  logic                             data_valid,
   output logic                             rd_req,
   input  logic [IN_W-1:0]                  din,
   output logic                             out_we,
   output logic [WC_W-1:0]                  out_addr,
   output logic [OUT_W-1:0]                 out_data,
   output logic                             evt_done,
   output logic                             hist_req,
   output logic [SADD_W+CHIP_W+STRIP_W-1:0] hist_addr,
   output logic [EVT_W-1:0]                 evt_count,
   output logic [ERR_W-1:0]                 err_count
);
   generate
      if (NUM_STREAMS < 1 || NUM_STREAMS > (1 << SADD_W)) begin : g_bad_streams
         $error("NUM_STREAMS does not fit the stream address");
      end
      if (1 + SADD_W + CHIP_W + STRIP_W != OUT_W) begin : g_bad_format
         $error("decoded word layout does not fill the output word");
      end
      if (WC_W < 3 || WC_W > OUT_W - 2) begin : g_bad_wc
         $error("word count width out of range");
      end
      if (EVT_W <= OUT_W || EVT_W > 2 * OUT_W) begin : g_bad_evt
         $error("event counter must span two header words");
      end
      if (ERR_W < 1 || ERR_W > OUT_W) begin : g_bad_err
         $error("error counter must fit one header word");
      end
   endgenerate

   logic              accept, evt_start, scan_end, deliver, hdr_active, err_flag;
   logic [HIDX_W-1:0] hdr_idx;

   evb_scan #(.NUM_STREAMS(NUM_STREAMS), .SADD_W(SADD_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sample_all(sample_all),
      .page_free(page_free), .stream_en(stream_en), .data_valid(data_valid),
      .eos(din[IN_W-1]), .sadd(sadd), .rd_req(rd_req), .accept(accept),
      .evt_start(evt_start), .scan_end(scan_end), .deliver(deliver),
      .hdr_active(hdr_active), .hdr_idx(hdr_idx)
   );

   evb_format #(.SADD_W(SADD_W), .WC_W(WC_W), .EVT_W(EVT_W), .ERR_W(ERR_W)) u_fmt (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .raw_mode(raw_mode),
      .deliver(deliver), .accept(accept), .sadd(sadd), .din(din),
      .hdr_active(hdr_active), .hdr_idx(hdr_idx), .evt_count(evt_count),
      .err_count(err_count), .out_we(out_we), .out_addr(out_addr),
      .out_data(out_data), .evt_done(evt_done), .hist_req(hist_req),
      .hist_addr(hist_addr), .err_flag(err_flag)
   );

   evb_count #(.EVT_W(EVT_W), .ERR_W(ERR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .scan_end(scan_end), .err_flag(err_flag),
      .evt_count(evt_count), .err_count(err_count)
   );
endmodule

// File: tb/sim_evt_assembler.sv
`timescale 1ns/1ps
module sim_evt_assembler;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, rd_en, sample_all, raw_mode, page_free;
   logic [3:0]  sadd;
   logic        stream_en, data_valid, rd_req;
   logic [8:0]  din;
   logic        out_we, evt_done, hist_req;
   logic [13:0] out_addr;
   logic [15:0] out_data;
   logic [14:0] hist_addr;
   logic [31:0] evt_count;
   logic [15:0] err_count;

   evt_assembler u0 (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sample_all(sample_all),
      .raw_mode(raw_mode), .page_free(page_free), .sadd(sadd),
      .stream_en(stream_en), .data_valid(data_valid), .rd_req(rd_req),
      .din(din), .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
      .evt_done(evt_done), .hist_req(hist_req), .hist_addr(hist_addr),
      .evt_count(evt_count), .err_count(err_count)
   );

   // FIFO models, one per stream
   logic [8:0]  mem [12][128];
   logic [6:0]  wr_ptr [12];
   logic [6:0]  rd_ptr [12];
   logic [11:0] mask_r;
   logic        bubble, phase;

   assign stream_en  = mask_r[sadd];
   assign data_valid = (rd_ptr[sadd] != wr_ptr[sadd]) && !(bubble && phase);
   assign din        = mem[sadd][rd_ptr[sadd]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 12; i++) rd_ptr[i] <= '0;
         phase <= 1'b0;
      end else begin
         phase <= ~phase;
         if (rd_req && data_valid) rd_ptr[sadd] <= rd_ptr[sadd] + 1'b1;
      end
   end

   int n_cmp = 0, n_bad = 0;
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected event
   logic [15:0] exp_w [256];
   logic [14:0] exp_h [256];
   int exp_n, exp_hn;
   bit exp_err;
   logic [31:0] exp_evt = 0;
   logic [15:0] exp_errc = 0;

   // monitor
   logic [15:0] got [256];
   int n_we = 0, n_hist = 0, n_rdreq = 0, n_done = 0, h_base = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_we) begin got[out_addr[7:0]] = out_data; n_we++; end
         if (rd_req) n_rdreq++;
         if (evt_done) n_done++;
         if (hist_req) begin
            chk(hist_addr == exp_h[(n_hist - h_base) & 255], "R6 hist_addr", 32'(hist_addr),
                32'(exp_h[(n_hist - h_base) & 255]));
            n_hist++;
         end
      end
   end

   task automatic push(input int s, input logic [8:0] w);
      mem[s][wr_ptr[s]] = w;
      wr_ptr[s] = wr_ptr[s] + 1'b1;
   endtask

   // Builds stream contents and the expected event
   task automatic build(input logic [11:0] m, input bit raw, input int nw,
                        input logic [7:0] seed, input bit err);
      logic [3:0] chip;
      logic [6:0] strip;
      logic [8:0] w;
      mask_r = m;
      exp_n = 4; exp_hn = 0; exp_err = err && !raw;
      h_base = n_hist;
      for (int s = 0; s < 12; s++) begin
         if (m[s]) begin
            chip = 4'(s + seed);
            w = {2'b01, (err ? 3'b010 : 3'b000), chip};
            push(s, w);
            if (raw) begin exp_w[exp_n] = {3'b0, 4'(s), w}; exp_n++; end
            for (int k = 0; k < nw; k++) begin
               strip = 7'(seed + s * 9 + k * 5);
               w = {2'b00, strip};
               push(s, w);
               if (raw) exp_w[exp_n] = {3'b0, 4'(s), w};
               else begin
                  exp_w[exp_n] = {1'b0, 4'(s), chip, strip};
                  exp_h[exp_hn] = {4'(s), chip, strip};
                  exp_hn++;
               end
               exp_n++;
            end
            w = {2'b10, seed[6:0]};
            push(s, w);
            exp_w[exp_n] = raw ? {3'b0, 4'(s), w} : {1'b1, 3'b0, 4'(s), 8'h00};
            exp_n++;
         end
      end
      raw_mode = raw;
      exp_evt++;
      if (exp_err) exp_errc++;
   endtask

   int we_base, done_base;
   logic [31:0] ev_base;
   task automatic arm;
      we_base = n_we; done_base = n_done; ev_base = evt_count;
   endtask

   task automatic wait_evt;
      int i;
      for (i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (evt_count != ev_base) break;
      end
      chk(i < 3000, "R3 event completion", evt_count, ev_base + 1);
      repeat (6) @(negedge clk);
   endtask

   task automatic verify(input bit dlv, input string tag);
      int bad;
      logic [15:0] h0;
      h0 = {1'b0, exp_err, 14'(exp_n)};
      chk(evt_count == exp_evt, {tag, " R10 evt_count"}, evt_count, exp_evt);
      chk(err_count == exp_errc, {tag, " R11 err_count"}, 32'(err_count), 32'(exp_errc));
      chk(n_hist - h_base == exp_hn, {tag, " R6 hist count"}, n_hist - h_base, exp_hn);
      chk(sadd == 4'd0, {tag, " R2 address wrap"}, 32'(sadd), 0);
      chk(n_done - done_base == int'(dlv), {tag, " R9 evt_done count"}, n_done - done_base, int'(dlv));
      chk(n_we - we_base == (dlv ? exp_n : 0), {tag, " R9 write count"}, n_we - we_base, dlv ? exp_n : 0);
      if (dlv) begin
         chk(got[0] == h0, {tag, " R7 header0"}, 32'(got[0]), 32'(h0));
         chk(got[1] == exp_errc, {tag, " R7 header1"}, 32'(got[1]), 32'(exp_errc));
         chk(got[2] == exp_evt[15:0], {tag, " R10 header2"}, 32'(got[2]), 32'(exp_evt[15:0]));
         chk(got[3] == exp_evt[31:16], {tag, " R10 header3"}, 32'(got[3]), 32'(exp_evt[31:16]));
         bad = 0;
         for (int a = 4; a < exp_n; a++) if (got[a] !== exp_w[a]) bad++;
         chk(bad == 0, {tag, " R5/R6 body words"}, bad, 0);
      end
   endtask

   task automatic pulse_start;
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   // {mask[26:15], raw[14], nw[13:10], seed[9:2], err[1], bubble[0]}
   localparam logic [26:0] VEC [6] = '{
      {12'hFFF, 1'b0, 4'd3, 8'h11, 1'b0, 1'b0},
      {12'h0A5, 1'b1, 4'd2, 8'h40, 1'b0, 1'b1},
      {12'h801, 1'b0, 4'd5, 8'h23, 1'b1, 1'b0},
      {12'h000, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0},
      {12'hFFF, 1'b1, 4'd0, 8'h07, 1'b1, 1'b1},
      {12'h3C0, 1'b0, 4'd7, 8'h5A, 1'b0, 1'b1}
   };

   initial begin
      #(150000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int rq0;
      for (int i = 0; i < 12; i++) wr_ptr[i] = '0;
      mask_r = '0; bubble = 1'b0;
      rst_n = 1'b0; rd_en = 1'b0; sample_all = 1'b1; raw_mode = 1'b0; page_free = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(sadd == 0, "R12 sadd", 32'(sadd), 0);
      chk(!rd_req && !out_we && !hist_req && !evt_done, "R12 strobes",
          {rd_req, out_we, hist_req, evt_done}, 0);
      chk(evt_count == 0 && err_count == 0, "R12 counters", evt_count, 0);

      // R1: data waiting, readout disabled
      arm();
      build(12'h001, 1'b0, 2, 8'h33, 1'b0);
      rq0 = n_rdreq;
      repeat (40) @(negedge clk);
      chk(n_rdreq == rq0, "R1 no request while disabled", n_rdreq - rq0, 0);
      chk(evt_count == ev_base, "R1 no event while disabled", evt_count, ev_base);
      pulse_start(); wait_evt(); verify(1'b1, "R1 run");

      // table walk
      foreach (VEC[v]) begin
         bubble = VEC[v][0];
         arm();
         build(VEC[v][26:15], VEC[v][14], int'(VEC[v][13:10]), VEC[v][9:2], VEC[v][1]);
         pulse_start(); wait_evt(); verify(1'b1, $sformatf("R3 vec%0d", v));
      end
      bubble = 1'b0;

      // R4: enabled stream 1 with empty FIFO
      arm();
      mask_r = 12'h002; raw_mode = 1'b0;
      pulse_start();
      repeat (30) @(negedge clk);
      chk(sadd == 4'd1, "R4 stall address (R2 skip of stream 0)", 32'(sadd), 1);
      chk(rd_req == 1'b1, "R4 request held", 32'(rd_req), 1);
      chk(evt_count == ev_base, "R4 no completion", evt_count, ev_base);
      build(12'h002, 1'b0, 3, 8'h61, 1'b0);
      wait_evt(); verify(1'b1, "R4 release");

      // R8: sample-all waits for a page
      sample_all = 1'b1; page_free = 1'b0;
      arm();
      build(12'h010, 1'b0, 2, 8'h0C, 1'b0);
      rq0 = n_rdreq;
      rd_en = 1'b1;
      repeat (30) @(negedge clk);
      chk(n_rdreq == rq0, "R8 no request without page", n_rdreq - rq0, 0);
      chk(evt_count == ev_base, "R8 no event without page", evt_count, ev_base);
      page_free = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      wait_evt(); verify(1'b1, "R8 resumed");

      // R9: full speed, no page -> histogram only
      sample_all = 1'b0; page_free = 1'b0;
      arm();
      build(12'h104, 1'b0, 4, 8'h2B, 1'b0);
      pulse_start(); wait_evt(); verify(1'b0, "R9 dropped");

      // R9: page present at start, removed mid-event -> still delivered
      page_free = 1'b1;
      arm();
      build(12'h050, 1'b0, 4, 8'h19, 1'b0);
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) begin rd_en = 1'b0; page_free = 1'b0; end
      wait_evt(); verify(1'b1, "R9 kept");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule